// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sequences power-down for a small microcontroller core. The instruction decoder sends a one-cycle strobe when it meets a sleep instruction. The block then decides whether that sleep is carried out. If it is, the block gates the core clock, clears the watchdog and updates two status bits. While the core sleeps, the block watches the per-source interrupt flags and their enables, the watchdog time-out and the external reset. It resumes the core when one of them fires. All logic runs on the free-running oscillator clock.

When an enabled interrupt is already pending at the strobe, the sleep is dropped as a no-op. Any enabled interrupt source wakes the core, whatever the global interrupt enable says. The global enable only decides what happens after the wake-up. If it is clear, the core continues in line. If it is set, the core finishes the instruction it had prefetched and then takes the interrupt vector. In crystal oscillator modes the core clock stays off for a start-up wait after the wake event. In RC mode the clock restarts at once.

Top module: `slp_wake_ctrl`

## Requirements
- R1: After `rst` the block is awake: `clk_en`=1, `sleeping`=0, `stat_nosleep`=1, `stat_nowdt`=1, `vec_take`=0, `wdt_clr`=0.
- R2: A `sleep_req` strobe with no source that has both flag and enable set is carried out. On the next cycle `sleeping`=1, `clk_en`=0, `stat_nosleep`=0, `stat_nowdt`=1, and `wdt_clr` is high for exactly that one cycle.
- R3: A `sleep_req` strobe while some bit of `irq_flag & irq_en` is 1 is a no-op. `sleeping` stays 0, `wdt_clr` stays 0, and both status bits keep their values.
- R4: While asleep, a source whose `irq_en` bit is 0 never wakes the core, even when its flag is 1.
- R5: An enabled flag wakes the core for either value of `gie`. With `gie`=0, `vec_take` stays 0. With `gie`=1, `vec_take` is high for one cycle, the cycle right after the first cycle in which `clk_en` is 1 again.
- R6: With `osc_xtal`=1, `clk_en` returns OST_CYCLES+1 clocks after the clock edge that samples the wake event. With `osc_xtal`=0, it returns 1 clock after that edge.
- R7: A `wdt_timeout` while asleep wakes the core. It clears `stat_nowdt`, leaves `stat_nosleep` at 0 and never raises `vec_take`.
- R8: `ext_rst` in any state makes the block awake on the next cycle, with `stat_nosleep`=1, `stat_nowdt`=1 and no vector.
- R9: When wake events coincide, `ext_rst` beats `wdt_timeout`, and `wdt_timeout` beats interrupts. A watchdog wake together with an interrupt gives `stat_nowdt`=0 and no vector.
- R10: A watchdog time-out or an interrupt that arrives during the start-up wait does not shorten the wait and does not change `stat_nowdt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| sleep_req | input | 1 | One-cycle strobe from the instruction decoder |
| irq_flag | input | N_IRQ | Interrupt flag per source |
| irq_en | input | N_IRQ | Interrupt enable per source |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| ext_rst | input | 1 | External reset request |
| osc_xtal | input | 1 | 1 = crystal mode with start-up wait, 0 = RC mode |
| clk_en | output | 1 | Core clock enable |
| sleeping | output | 1 | Core clock is gated (sleep or start-up wait) |
| vec_take | output | 1 | One-cycle pulse: branch to the interrupt vector |
| wdt_clr | output | 1 | One-cycle watchdog clear pulse on sleep entry |
| stat_nosleep | output | 1 | 1 after power-up, 0 once a sleep is carried out |
| stat_nowdt | output | 1 | 0 when a watchdog time-out ended the sleep |

## Verification
On every cycle the assertions check the following. Sleep entry always comes with a watchdog clear and the updated status bits. A pending enabled interrupt always blocks entry. An external reset always gives the power-up status. A watchdog wake always clears its bit. A sleeping core with no live wake cause stays in the sleep state. A vector pulse only ever follows an awake cycle. Only the bench scenarios can show the exact wake-up latency in each oscillator mode, the choice between vectoring and continuing in line for each source and each `gie` value, the priority among coinciding events, and that late events do not disturb the start-up wait.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_OST   = 2'd2,
        ST_POST  = 2'd3
    } slp_state_e;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_IRQ  = 2'd1,
        WK_WDT  = 2'd2,
        WK_EXT  = 2'd3
    } wake_cause_e;

    typedef struct packed {
        logic nosleep;
        logic nowdt;
    } slp_status_t;

    localparam slp_status_t STATUS_POWERUP = '{nosleep: 1'b1, nowdt: 1'b1};

    function automatic slp_state_e wake_target(input logic xtal);
        return xtal ? ST_OST : ST_POST;
    endfunction

    function automatic logic clock_gated(input slp_state_e s);
        return (s == ST_SLEEP) || (s == ST_OST);
    endfunction

endpackage

// File: rtl/slp_wake_arbiter.sv
module slp_wake_arbiter
    import slp_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  logic [N_IRQ-1:0] irq_flag,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_timeout,
    input  logic             ext_rst,
    output logic             irq_armed,
    output wake_cause_e      cause
);
    logic [N_IRQ-1:0] armed_vec;

    genvar gi;
    generate
        for (gi = 0; gi < N_IRQ; gi++) begin : g_src
            assign armed_vec[gi] = irq_flag[gi] & irq_en[gi];
        end
    endgenerate

    assign irq_armed = |armed_vec;

    always_comb begin
        if (ext_rst)          cause = WK_EXT;
        else if (wdt_timeout) cause = WK_WDT;
        else if (irq_armed)   cause = WK_IRQ;
        else                  cause = WK_NONE;
    end
endmodule

// File: rtl/slp_ost_counter.sv
module slp_ost_counter #(
    parameter int OST_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int CW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (run)     cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/slp_status_bits.sv
module slp_status_bits
    import slp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ext_rst,
    input  logic        enter,
    input  logic        wdt_wake,
    output slp_status_t status
);
    always_ff @(posedge clk) begin
        if (rst || ext_rst) begin
            status <= STATUS_POWERUP;
        end else if (enter) begin
            status.nosleep <= 1'b0;
            status.nowdt   <= 1'b1;
        end else if (wdt_wake) begin
            status.nowdt   <= 1'b0;
        end
    end
endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
    import slp_pkg::*;
#(
    parameter int N_IRQ      = 4,
    parameter int OST_CYCLES = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic [N_IRQ-1:0] irq_flag,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             gie,
    input  logic             wdt_timeout,
    input  logic             ext_rst,
    input  logic             osc_xtal,
    output logic             clk_en,
    output logic             sleeping,
    output logic             vec_take,
    output logic             wdt_clr,
    output logic             stat_nosleep,
    output logic             stat_nowdt
);
    slp_state_e  state;
    wake_cause_e cause;
    slp_status_t status;
    logic        irq_armed;
    logic        ost_done;
    logic        vec_pend;
    logic        enter;
    logic        wake;
    logic        wdt_wake;

    slp_wake_arbiter #(.N_IRQ(N_IRQ)) u_arb (
        .irq_flag    (irq_flag),
        .irq_en      (irq_en),
        .wdt_timeout (wdt_timeout),
        .ext_rst     (ext_rst),
        .irq_armed   (irq_armed),
        .cause       (cause)
    );

    assign enter    = (state == ST_RUN) && sleep_req && !irq_armed && !ext_rst;
    assign wake     = (state == ST_SLEEP) && (cause == WK_IRQ || cause == WK_WDT);
    assign wdt_wake = (state == ST_SLEEP) && (cause == WK_WDT);

    slp_ost_counter #(.OST_CYCLES(OST_CYCLES)) u_ost (
        .clk   (clk),
        .rst   (rst),
        .clear (enter),
        .run   (state == ST_OST),
        .done  (ost_done)
    );

    slp_status_bits u_stat (
        .clk      (clk),
        .rst      (rst),
        .ext_rst  (ext_rst),
        .enter    (enter),
        .wdt_wake (wdt_wake),
        .status   (status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RUN;
            vec_pend <= 1'b0;
            vec_take <= 1'b0;
            wdt_clr  <= 1'b0;
        end else begin
            vec_take <= 1'b0;
            wdt_clr  <= 1'b0;
            if (ext_rst) begin
                state    <= ST_RUN;
                vec_pend <= 1'b0;
            end else begin
                unique case (state)
                    ST_RUN: begin
                        if (enter) begin
                            state   <= ST_SLEEP;
                            wdt_clr <= 1'b1;
                        end
                    end
                    ST_SLEEP: begin
                        if (wake) begin
                            vec_pend <= (cause == WK_IRQ) && gie;
                            state    <= wake_target(osc_xtal);
                        end
                    end
                    ST_OST: begin
                        if (ost_done) state <= ST_POST;
                    end
                    ST_POST: begin
                        state    <= ST_RUN;
                        vec_take <= vec_pend;
                        vec_pend <= 1'b0;
                    end
                    default: state <= ST_RUN;
                endcase
            end
        end
    end

    assign sleeping     = clock_gated(state);
    assign clk_en       = !sleeping;
    assign stat_nosleep = status.nosleep;
    assign stat_nowdt   = status.nowdt;
endmodule

// File: rtl/slp_wake_ctrl_chk.sv
module slp_wake_ctrl_chk
    import slp_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             sleep_req,
    input logic [N_IRQ-1:0] irq_flag,
    input logic [N_IRQ-1:0] irq_en,
    input logic             wdt_timeout,
    input logic             ext_rst,
    input logic             clk_en,
    input logic             sleeping,
    input logic             vec_take,
    input logic             wdt_clr,
    input logic             stat_nosleep,
    input logic             stat_nowdt,
    input slp_state_e       state
);
    logic any_live;
    assign any_live = |(irq_flag & irq_en);

    assert_entry_clears_wdt_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sleeping) |-> wdt_clr && !stat_nosleep && stat_nowdt);

    assert_pending_blocks_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && any_live && clk_en) |=> !sleeping && !wdt_clr);

    assert_idle_sleep_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && !any_live && !wdt_timeout && !ext_rst) |=> state == ST_SLEEP);

    assert_vector_after_awake_R5: assert property (@(posedge clk) disable iff (rst)
        vec_take |-> clk_en && $past(clk_en));

    assert_wdt_wake_status_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && wdt_timeout && !ext_rst) |=> !stat_nowdt && !vec_take);

    assert_ext_reset_status_R8: assert property (@(posedge clk) disable iff (rst)
        ext_rst |=> stat_nosleep && stat_nowdt && !sleeping && !vec_take);
endmodule

bind slp_wake_ctrl slp_wake_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sleep_req    (sleep_req),
    .irq_flag     (irq_flag),
    .irq_en       (irq_en),
    .wdt_timeout  (wdt_timeout),
    .ext_rst      (ext_rst),
    .clk_en       (clk_en),
    .sleeping     (sleeping),
    .vec_take     (vec_take),
    .wdt_clr      (wdt_clr),
    .stat_nosleep (stat_nosleep),
    .stat_nowdt   (stat_nowdt),
    .state        (state)
);

// File: tb/slp_wake_ctrl_test.sv
`timescale 1ns/1ps
module slp_wake_ctrl_test;
    localparam int N   = 4;
    localparam int OST = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b0;
    logic [N-1:0] irq_flag = '0;
    logic [N-1:0] irq_en = '0;
    logic gie = 1'b0;
    logic wdt_timeout = 1'b0;
    logic ext_rst = 1'b0;
    logic osc_xtal = 1'b0;
    logic clk_en, sleeping, vec_take, wdt_clr, stat_nosleep, stat_nowdt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    slp_wake_ctrl #(.N_IRQ(N), .OST_CYCLES(OST)) uut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .irq_flag(irq_flag),
        .irq_en(irq_en), .gie(gie), .wdt_timeout(wdt_timeout), .ext_rst(ext_rst),
        .osc_xtal(osc_xtal), .clk_en(clk_en), .sleeping(sleeping),
        .vec_take(vec_take), .wdt_clr(wdt_clr), .stat_nosleep(stat_nosleep),
        .stat_nowdt(stat_nowdt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic enter_sleep();
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        chk("R2 sleeping", sleeping, 1);
        chk("R2 clk_en", clk_en, 0);
        chk("R2 wdt_clr", wdt_clr, 1);
        chk("R2 nosleep", stat_nosleep, 0);
        chk("R2 nowdt", stat_nowdt, 1);
        tick();
        chk("R2 wdt_clr single", wdt_clr, 0);
    endtask

    task automatic wait_awake(output int lat);
        lat = 1;
        tick();
        while (!clk_en && lat < 200) begin
            tick();
            lat++;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        @(negedge clk);
        tick();
        tick();
        rst = 1'b0;
        // R1 reset state
        chk("R1 clk_en", clk_en, 1);
        chk("R1 sleeping", sleeping, 0);
        chk("R1 nosleep", stat_nosleep, 1);
        chk("R1 nowdt", stat_nowdt, 1);
        chk("R1 vec_take", vec_take, 0);
        chk("R1 wdt_clr", wdt_clr, 0);

        // R3 no-op with pending enabled source, for every source
        for (int s = 0; s < N; s++) begin
            irq_en = N'(1) << s;
            irq_flag = N'(1) << s;
            sleep_req = 1'b1;
            tick();
            sleep_req = 1'b0;
            chk("R3 sleeping", sleeping, 0);
            chk("R3 wdt_clr", wdt_clr, 0);
            chk("R3 nosleep", stat_nosleep, 1);
            chk("R3 nowdt", stat_nowdt, 1);
        end
        irq_flag = '0;

        // R4 R5 R6 sweep: mode x gie x source
        for (int xt = 0; xt < 2; xt++) begin
            for (int g = 0; g < 2; g++) begin
                for (int s = 0; s < N; s++) begin
                    osc_xtal = xt[0];
                    gie = g[0];
                    irq_en = N'(1) << s;
                    irq_flag = '0;
                    enter_sleep();
                    irq_flag = ~(N'(1) << s);
                    tick(); tick(); tick();
                    chk("R4 disabled sources keep sleep", sleeping, 1);
                    irq_flag = irq_flag | (N'(1) << s);
                    wait_awake(lat);
                    chk("R6 wake latency", lat, (xt == 1) ? OST + 1 : 1);
                    chk("R5 vec not during resume", vec_take, 0);
                    chk("R5 nowdt kept", stat_nowdt, 1);
                    tick();
                    chk("R5 vector choice", vec_take, g);
                    tick();
                    chk("R5 vector single", vec_take, 0);
                    irq_flag = '0;
                end
            end
        end

        // R7 watchdog wake, gie set, RC mode
        osc_xtal = 1'b0; gie = 1'b1; irq_en = '1; irq_flag = '0;
        enter_sleep();
        wdt_timeout = 1'b1;
        tick();
        wdt_timeout = 1'b0;
        chk("R7 nowdt cleared", stat_nowdt, 0);
        chk("R7 nosleep stays", stat_nosleep, 0);
        chk("R7 awake", clk_en, 1);
        tick();
        chk("R7 no vector", vec_take, 0);

        // R9 watchdog beats interrupt
        enter_sleep();
        wdt_timeout = 1'b1; irq_flag = 4'b0010;
        tick();
        wdt_timeout = 1'b0;
        chk("R9 wdt over irq nowdt", stat_nowdt, 0);
        tick();
        chk("R9 wdt over irq no vector", vec_take, 0);
        irq_flag = '0;

        // R9 / R8 external reset beats watchdog
        enter_sleep();
        ext_rst = 1'b1; wdt_timeout = 1'b1;
        tick();
        ext_rst = 1'b0; wdt_timeout = 1'b0;
        chk("R9 ext over wdt nowdt", stat_nowdt, 1);
        chk("R8 nosleep set", stat_nosleep, 1);
        chk("R8 awake", sleeping, 0);
        tick();
        chk("R8 no vector", vec_take, 0);

        // R8 external reset during start-up wait
        osc_xtal = 1'b1; gie = 1'b1;
        enter_sleep();
        irq_flag = 4'b0001;
        tick(); tick();
        chk("R8 in start-up wait", sleeping, 1);
        ext_rst = 1'b1;
        tick();
        ext_rst = 1'b0;
        chk("R8 ext during wait awake", clk_en, 1);
        chk("R8 ext during wait nosleep", stat_nosleep, 1);
        tick();
        chk("R8 ext during wait no vector", vec_take, 0);
        irq_flag = '0;

        // R10 watchdog during start-up wait
        gie = 1'b0;
        enter_sleep();
        irq_flag = 4'b0100;
        tick();
        lat = 1;
        wdt_timeout = 1'b1;
        tick(); lat++;
        wdt_timeout = 1'b0;
        while (!clk_en && lat < 200) begin
            tick();
            lat++;
        end
        chk("R10 latency unchanged", lat, OST + 1);
        chk("R10 nowdt unchanged", stat_nowdt, 1);
        irq_flag = '0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule